// File: doc/BRIEF.md
# Watchdog Wakeup Reset Supervisor

This block supervises a microcontroller that spends most of its time asleep. It produces a periodic wakeup square wave that interrupts the sleeping controller. It watches a watchdog line, where the controller must show at least one falling edge per wakeup cycle. It also drives an active-low reset that holds the controller whenever supply power is not good, or when the watchdog was not serviced.

All timing comes from one shared time unit. A prescaler divides the clock by `UNIT_CYC`, and every interval is a whole number of these units:

- a wakeup cycle of `CYC_UNITS` units, high for the first half and low for the second;
- a reset release delay of `RST_UNITS` units;
- a gap of `START_UNITS` units from reset release to the first wakeup rise.

The power-good flag comes from an external voltage comparator and arrives as a digital level. It passes through a two-flop synchronizer, and so does the watchdog line.

A wakeup cycle starts at the wakeup rising edge. The first watchdog falling edge seen in a cycle ends the high phase early. If a cycle closes without any such edge, the block issues a reset at that cycle boundary. The reset then releases, and the start-up sequence repeats.

Top module: `wd_wake_sup`

## Requirements
- R1: While `rst_ni` is low, `rst_no` and `wake_o` are both 0.
- R2: `pg_i` low, after two synchronizer flops, drives `rst_no` low at the third clock edge after the change. `rst_no` stays low for as long as `pg_i` stays low.
- R3: After `pg_i` returns high, `rst_no` goes high exactly 3 + `RST_UNITS`*`UNIT_CYC` clock edges later.
- R4: After `rst_no` rises, `wake_o` stays low for `START_UNITS`*`UNIT_CYC` clock edges and then rises.
- R5: If no watchdog falling edge lands in the high phase, `wake_o` is high for (`CYC_UNITS`/2)*`UNIT_CYC` edges and low for the rest of the `CYC_UNITS`*`UNIT_CYC`-edge cycle. A serviced cycle is followed at once by the next one.
- R6: The first falling edge of `wd_i` in a cycle pulls `wake_o` low 3 clock edges later. `wake_o` then stays low until the next cycle begins.
- R7: Further `wd_i` falling edges in the same cycle, and all `wd_i` rising edges, have no effect. In particular they do not service the following cycle.
- R8: If a cycle ends with no `wd_i` falling edge, `rst_no` falls exactly `CYC_UNITS`*`UNIT_CYC` edges after that cycle's wakeup rise. The R3-length delay and then the R4 sequence follow.
- R9: `wake_o` is never high while `rst_no` is low.
- R10: A `pg_i` loss during a watchdog reset pre-empts it. The reset is then released only 3 + `RST_UNITS`*`UNIT_CYC` edges after `pg_i` is restored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg_i | input | 1 | Power-good flag from external comparator, asynchronous |
| wd_i | input | 1 | Watchdog line from the controller, asynchronous, falling edge sensed |
| wake_o | output | 1 | Wakeup square wave |
| rst_no | output | 1 | Active-low reset to the controller |

## Verification
On every clock, the assertions check the following:
- reset falls after a synchronized power loss;
- reset and wakeup rises happen only on unit ticks;
- wakeup stays low once a cycle is serviced;
- an unserviced cycle end forces reset.

The exact interval lengths can only be shown by the bench's scenarios. So can the claims that depend on sequence: surplus watchdog edges are not carried into the next cycle, and a power drop stretches a reset already in progress. A behavioural per-clock model checks both outputs throughout those scenarios.

// File: rtl/wd_wake_sup_pkg.sv
package wd_wake_sup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,  // power not good, reset held
    ST_RST   = 2'd1,  // reset release delay
    ST_START = 2'd2,  // reset high, waiting for first wakeup
    ST_CYC   = 2'd3   // wakeup cycles running
  } sup_state_e;
endpackage

// File: rtl/wd_wake_sync.sv
module wd_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/wd_wake_prescale.sv
module wd_wake_prescale #(
  parameter int UNIT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (UNIT_CYC <= 1) begin : g_passthru
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(UNIT_CYC);
      localparam logic [PW-1:0] LAST = PW'(UNIT_CYC - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              pcnt <= '0;
        else if (clr_i)           pcnt <= '0;
        else if (pcnt == LAST)    pcnt <= '0;
        else                      pcnt <= pcnt + 1'b1;
      end

      assign tick_o = (pcnt == LAST) && !clr_i;
    end
  endgenerate
endmodule

// File: rtl/wd_wake_sup.sv
module wd_wake_sup
  import wd_wake_sup_pkg::*;
#(
  parameter int UNIT_CYC    = 1000,
  parameter int CYC_UNITS   = 8,
  parameter int RST_UNITS   = 1,
  parameter int START_UNITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_i,
  input  logic wd_i,
  output logic wake_o,
  output logic rst_no
);
  localparam int HI_UNITS = CYC_UNITS / 2;
  localparam int MAX_A    = (CYC_UNITS > START_UNITS) ? CYC_UNITS : START_UNITS;
  localparam int MAXU     = (MAX_A > RST_UNITS) ? MAX_A : RST_UNITS;
  localparam int UW       = (MAXU > 1) ? $clog2(MAXU) : 1;
  localparam logic [UW-1:0] CYC_LAST   = UW'(CYC_UNITS - 1);
  localparam logic [UW-1:0] RST_LAST   = UW'(RST_UNITS - 1);
  localparam logic [UW-1:0] START_LAST = UW'(START_UNITS - 1);
  localparam logic [UW-1:0] HI_LIM     = UW'(HI_UNITS);

  logic pg_sync, wd_sync, wd_prev, wd_fall, tick;
  sup_state_e state_q, state_d;
  logic [UW-1:0] ucnt_q, ucnt_d;
  logic svc_q, svc_d;

  wd_wake_sync #(.STAGES(2)) u_pg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pg_i), .q_o(pg_sync)
  );
  wd_wake_sync #(.STAGES(2)) u_wd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wd_i), .q_o(wd_sync)
  );
  wd_wake_prescale #(.UNIT_CYC(UNIT_CYC)) u_prescale (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(state_q == ST_HOLD), .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wd_prev <= 1'b0;
    else         wd_prev <= wd_sync;
  end
  assign wd_fall = wd_prev && !wd_sync;

  always_comb begin
    state_d = state_q;
    ucnt_d  = ucnt_q;
    svc_d   = svc_q;
    if (!pg_sync) begin
      // power loss overrides every other state, including a timeout reset
      state_d = ST_HOLD;
      ucnt_d  = '0;
      svc_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          state_d = ST_RST;
          ucnt_d  = '0;
        end
        ST_RST: if (tick) begin
          if (ucnt_q == RST_LAST) begin
            state_d = ST_START;
            ucnt_d  = '0;
          end else ucnt_d = ucnt_q + 1'b1;
        end
        ST_START: if (tick) begin
          if (ucnt_q == START_LAST) begin
            state_d = ST_CYC;
            ucnt_d  = '0;
            svc_d   = 1'b0;
          end else ucnt_d = ucnt_q + 1'b1;
        end
        ST_CYC: begin
          if (wd_fall) svc_d = 1'b1;
          if (tick) begin
            if (ucnt_q == CYC_LAST) begin
              ucnt_d = '0;
              svc_d  = 1'b0;
              if (!(svc_q || wd_fall)) state_d = ST_RST;
            end else ucnt_d = ucnt_q + 1'b1;
          end
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      ucnt_q  <= '0;
      svc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ucnt_q  <= ucnt_d;
      svc_q   <= svc_d;
    end
  end

  assign rst_no = (state_q == ST_START) || (state_q == ST_CYC);
  assign wake_o = (state_q == ST_CYC) && !svc_q && (ucnt_q < HI_LIM);

  // R2
  pg_loss_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_sync |=> !rst_no);

  // R3
  rst_rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> ($past(tick) && $past(pg_sync)));

  // R5
  wake_rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(tick));

  // R6
  wd_service_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CYC && (wd_fall || svc_q) && !(tick && ucnt_q == CYC_LAST)) |=> !wake_o);

  // R8
  timeout_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CYC && tick && ucnt_q == CYC_LAST && !svc_q && !wd_fall) |=> !rst_no);

  // R9
  wake_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_no |-> !wake_o);
endmodule

// File: tb/wd_wake_sup_bench.sv
module wd_wake_sup_bench;
  localparam int U     = 8;
  localparam int CYC   = 8;
  localparam int RSTU  = 1;
  localparam int START = 4;
  localparam int HI    = CYC / 2;

  logic clk_i = 1'b0;
  logic rst_ni, pg_i, wd_i;
  logic wake_o, rst_no;
  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  wd_wake_sup #(.UNIT_CYC(U), .CYC_UNITS(CYC), .RST_UNITS(RSTU), .START_UNITS(START)) u_wd_wake_sup (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_i(pg_i), .wd_i(wd_i), .wake_o(wake_o), .rst_no(rst_no)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 hold, 1 release delay, 2 start gap, 3 cycling
  int ph, el;
  bit svc, m_p1, m_p2, m_w1, m_w2, m_wp, m_fall;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph = 0; el = 0; svc = 0;
      m_p1 = 0; m_p2 = 0; m_w1 = 0; m_w2 = 0; m_wp = 0;
    end else begin
      m_fall = m_wp && !m_w2;
      if (!m_p2) begin
        ph = 0; el = 0; svc = 0;
      end else if (ph == 0) begin
        ph = 1; el = 0;
      end else if (ph == 1) begin
        if (el == RSTU * U - 1) begin ph = 2; el = 0; end else el++;
      end else if (ph == 2) begin
        if (el == START * U - 1) begin ph = 3; el = 0; svc = 0; end else el++;
      end else begin
        if (m_fall) svc = 1;
        if (el == CYC * U - 1) begin
          el = 0;
          if (svc) svc = 0; else ph = 1;
        end else el++;
      end
      m_wp = m_w2; m_w2 = m_w1; m_w1 = wd_i;
      m_p2 = m_p1; m_p1 = pg_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && !done) begin
      chk(rst_no === (ph >= 2), cur_req, rst_no, ph >= 2);
      chk(wake_o === (ph == 3 && !svc && el < HI * U), cur_req, wake_o, ph == 3 && !svc && el < HI * U);
      chk(!(wake_o && !rst_no), "R9", wake_o, 0);
    end
  end

  task automatic wait_wake(logic v);
    while (wake_o !== v) begin @(posedge clk_i); @(negedge clk_i); end
  endtask
  task automatic wait_rst(logic v);
    while (rst_no !== v) begin @(posedge clk_i); @(negedge clk_i); end
  endtask
  task automatic wd_pulse();
    wd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    wd_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, t1;
    rst_ni = 1'b0; pg_i = 1'b0; wd_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(rst_no === 1'b0, "R1", rst_no, 0);
    chk(wake_o === 1'b0, "R1", wake_o, 0);
    rst_ni = 1'b1;
    cur_req = "R2";
    repeat (4) @(negedge clk_i);
    chk(rst_no === 1'b0, "R2", rst_no, 0);

    cur_req = "R3";
    pg_i = 1'b1; t0 = cyc;
    wait_rst(1'b1);
    chk(cyc - t0 == 3 + RSTU * U, "R3", cyc - t0, 3 + RSTU * U);
    cur_req = "R4";
    t0 = cyc;
    wait_wake(1'b1);
    chk(cyc - t0 == START * U, "R4", cyc - t0, START * U);

    cur_req = "R5";
    for (int k = 0; k < 3; k++) begin
      t0 = cyc;
      wait_wake(1'b0);
      chk(cyc - t0 == HI * U, "R5", cyc - t0, HI * U);
      t1 = cyc;
      wd_pulse();
      wait_wake(1'b1);
      chk(cyc - t1 == (CYC - HI) * U, "R5", cyc - t1, (CYC - HI) * U);
      chk(rst_no === 1'b1, "R5", rst_no, 1);
    end

    cur_req = "R6";
    t0 = cyc;
    wd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    wd_i = 1'b0; t1 = cyc;
    wait_wake(1'b0);
    chk(cyc - t1 == 3, "R6", cyc - t1, 3);
    cur_req = "R7";
    wd_pulse();
    wd_pulse();
    chk(wake_o === 1'b0, "R7", wake_o, 0);
    wait_wake(1'b1);
    chk(cyc - t0 == CYC * U, "R6", cyc - t0, CYC * U);
    chk(rst_no === 1'b1, "R7", rst_no, 1);

    cur_req = "R8";
    t0 = cyc;
    wait_rst(1'b0);
    chk(cyc - t0 == CYC * U, "R8", cyc - t0, CYC * U);
    chk(wake_o === 1'b0, "R9", wake_o, 0);

    cur_req = "R10";
    pg_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(rst_no === 1'b0, "R10", rst_no, 0);
    pg_i = 1'b1; t0 = cyc;
    wait_rst(1'b1);
    chk(cyc - t0 == 3 + RSTU * U, "R10", cyc - t0, 3 + RSTU * U);
    cur_req = "R4";
    t0 = cyc;
    wait_wake(1'b1);
    chk(cyc - t0 == START * U, "R4", cyc - t0, START * U);

    cur_req = "R2";
    pg_i = 1'b0; t0 = cyc;
    wait_rst(1'b0);
    chk(cyc - t0 == 3, "R2", cyc - t0, 3);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      chk(rst_no === 1'b0, "R2", rst_no, 0);
      chk(wake_o === 1'b0, "R9", wake_o, 0);
    end
    pg_i = 1'b1;
    cur_req = "R3";
    repeat (2 * CYC * U) @(negedge clk_i);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule